// File: doc/BRIEF.md
# Two-Bank Instruction Cache Refill Controller

This block keeps a two-bank instruction cache supplied while a pattern sequencer executes from it. The cache has 2^ADDR_W entries split into two equal banks. The top bit of the sequencer's read address selects the bank. The controller reads that bit from the sequencer's clock domain. When execution crosses into the other bank, the controller asks a DMA engine to overwrite the bank just left with the next chunk from a large external instruction store. A run begins with a `start` pulse that carries the total instruction count. The controller first fills bank 0. It then notes bank 1 as the last bank used, so that bank 1 is fetched as soon as the sequencer is seen reading bank 0.

The DMA interface is a level request with a one-cycle acknowledge. While `dma_req` is high, the request carries a source offset into the external store, a destination bank and a length. Each chunk is one bank long, and the final chunk may be shorter. When the whole program has been requested and acknowledged, `done` rises and no further requests are made until the next start. The DMA engine, the cache RAM and the instruction execution are outside this block.

The control state machine has five states. IDLE waits for the first start. LOAD has the initial bank-0 transfer outstanding. WATCH compares the synchronized bank bit with the last bank used. REFILL has a refill transfer outstanding. DONE is entered when the program is exhausted. The transitions are as follows:
- IDLE/DONE to LOAD on start with a nonzero count.
- IDLE/DONE to DONE on start with a zero count.
- LOAD/REFILL to WATCH on an acknowledge while data remains.
- LOAD/REFILL to DONE on the acknowledge of the final chunk.
- WATCH to REFILL on a bank mismatch.

Top module: `pp_refill_ctrl`

## Requirements
- R1: After reset, `dma_req` and `done` are 0 and the block waits for `start`.
- R2: A `start` sampled with a nonzero `total_instr` raises `dma_req` after that clock edge, with `dma_src`=0, `dma_bank`=0 and `dma_len`=min(CHUNK, total), where CHUNK = 2^(ADDR_W-1) = 16384.
- R3: While `dma_req` is high and `dma_ack` is low, `dma_req`, `dma_src`, `dma_bank` and `dma_len` hold. `dma_req` is low in the cycle after `dma_ack` is sampled.
- R4: After the initial load, the last bank used is 1. If the sequencer bit shows bank 0, a refill of bank 1 is requested one cycle after the load acknowledge.
- R5: When the sequencer bank bit (`seq_rd_msb`, 0 = bank 0, 1 = bank 1) differs from the last bank used, a refill of the bank left (the last bank used) is requested on the third clock edge after the change. While the bit equals the last bank used, no request is made.
- R6: At most one transfer is outstanding at a time. A bank change seen during a transfer is kept pending and is requested one cycle after that transfer's acknowledge.
- R7: Transfer number i (0 = initial load) has `dma_src` = i*CHUNK and `dma_bank` = i mod 2.
- R8: `dma_len` is min(CHUNK, total - `dma_src`), so the final chunk may be short.
- R9: After the acknowledge of the chunk that reaches the total, `done` is 1 from the next cycle. No request follows, even on later bank changes, until a new start.
- R10: `start` is ignored in LOAD, WATCH and REFILL. `total_instr` is sampled only when a start is accepted.
- R11: A start with `total_instr`=0 sets `done` after that edge and issues no request.
- R12: A start accepted in DONE begins a new run from source offset 0 with bank 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run start pulse, accepted in IDLE or DONE |
| total_instr | input | SRC_W (23) | Number of instructions in the external store for this run |
| seq_rd_msb | input | 1 | Bank bit of the sequencer read address, from the sequencer clock domain |
| dma_req | output | 1 | Transfer request, held until acknowledged |
| dma_ack | input | 1 | One-cycle transfer completion strobe |
| dma_src | output | SRC_W (23) | Source offset in the external store, in instructions |
| dma_bank | output | 1 | Destination cache bank |
| dma_len | output | LEN_W (15) | Transfer length in instructions |
| done | output | 1 | Whole program has been transferred |

## Verification
Each result has a fixed latency, and the bench samples exactly there. A request appears one edge after an accepted start. It appears one edge after a load acknowledge when the sequencer already sits in bank 0. It appears three edges after a change of the sequencer bank bit (two synchronizer flops and the state register). `dma_req` falls, or `done` rises, on the edge that samples the acknowledge. The bench drives and samples one nanosecond after each rising edge and steps single edges around every such event. It checks both the cycles before the expected change and the cycle of the change. Random runs compute the source, bank and length of every transfer from the run's total, and the directed cases cover a pending change, a short final chunk, a zero total and an ignored start.

// File: rtl/pp_refill_pkg.sv
package pp_refill_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LOAD   = 3'd1,
        ST_WATCH  = 3'd2,
        ST_REFILL = 3'd3,
        ST_DONE   = 3'd4
    } refill_state_e;

endpackage

// File: rtl/bank_sync.sv
module bank_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES > 1) begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_in};
            end
        end else begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= async_in;
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/chunk_calc.sv
module chunk_calc #(
    parameter int SRC_W = 23,
    parameter int LEN_W = 15,
    parameter int CHUNK = 16384
) (
    input  logic [SRC_W-1:0] offset,
    input  logic [SRC_W-1:0] total,
    output logic [LEN_W-1:0] len,
    output logic [SRC_W-1:0] next_off,
    output logic             last
);

    localparam logic [SRC_W-1:0] CHUNK_S = SRC_W'(CHUNK);
    localparam logic [LEN_W-1:0] CHUNK_L = LEN_W'(CHUNK);

    logic [SRC_W-1:0] remaining;
    logic             full;

    always_comb begin
        remaining = total - offset;
        full      = (remaining >= CHUNK_S);
        len       = full ? CHUNK_L : LEN_W'(remaining);
        next_off  = offset + SRC_W'(len);
        last      = (remaining <= CHUNK_S);
    end

endmodule

// File: rtl/refill_fsm.sv
module refill_fsm
    import pp_refill_pkg::*;
#(
    parameter int SRC_W = 23,
    parameter int LEN_W = 15,
    parameter int CHUNK = 16384
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [SRC_W-1:0] total_in,
    input  logic             seq_bank,
    input  logic             dma_ack,
    input  logic [LEN_W-1:0] calc_len,
    input  logic [SRC_W-1:0] calc_next,
    input  logic             calc_last,
    output logic [SRC_W-1:0] calc_off,
    output logic [SRC_W-1:0] calc_total,
    output logic             dma_req,
    output logic [SRC_W-1:0] dma_src,
    output logic             dma_bank,
    output logic [LEN_W-1:0] dma_len,
    output logic             done
);

    refill_state_e state_q, state_d;

    logic [SRC_W-1:0] total_q;
    logic [SRC_W-1:0] offset_q;
    logic [SRC_W-1:0] src_q;
    logic [LEN_W-1:0] len_q;
    logic             bank_q;
    logic             final_q;
    logic             last_bank_q;

    logic accepting;
    logic launch;
    logic mismatch;

    assign accepting = (state_q == ST_IDLE) || (state_q == ST_DONE);
    assign launch    = accepting && start && (total_in != '0);
    assign mismatch  = (state_q == ST_WATCH) && (seq_bank != last_bank_q);

    assign calc_off   = accepting ? '0 : offset_q;
    assign calc_total = accepting ? total_in : total_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start) state_d = (total_in == '0) ? ST_DONE : ST_LOAD;
            end
            ST_LOAD, ST_REFILL: begin
                if (dma_ack) state_d = final_q ? ST_DONE : ST_WATCH;
            end
            ST_WATCH: begin
                if (seq_bank != last_bank_q) state_d = ST_REFILL;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // request bookkeeping, captured when a transfer is issued
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            total_q     <= '0;
            offset_q    <= '0;
            src_q       <= '0;
            len_q       <= '0;
            bank_q      <= 1'b0;
            final_q     <= 1'b0;
            last_bank_q <= 1'b0;
        end else if (launch) begin
            total_q     <= total_in;
            offset_q    <= calc_next;
            src_q       <= '0;
            len_q       <= calc_len;
            bank_q      <= 1'b0;
            final_q     <= calc_last;
            last_bank_q <= 1'b1;
        end else if (mismatch) begin
            offset_q    <= calc_next;
            src_q       <= offset_q;
            len_q       <= calc_len;
            bank_q      <= last_bank_q;
            final_q     <= calc_last;
            last_bank_q <= seq_bank;
        end
    end

    // outputs
    always_comb begin
        dma_req  = (state_q == ST_LOAD) || (state_q == ST_REFILL);
        done     = (state_q == ST_DONE);
        dma_src  = src_q;
        dma_bank = bank_q;
        dma_len  = len_q;
    end

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req && !dma_ack |=> dma_req && $stable(dma_src) && $stable(dma_bank) && $stable(dma_len));

    // R3
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req && dma_ack |=> !dma_req);

    // R8
    len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (dma_len != '0) && (dma_len <= LEN_W'(CHUNK)));

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done && !dma_req);

    // R2
    first_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_req) && (dma_src == '0) |-> !dma_bank);

endmodule

// File: rtl/pp_refill_ctrl.sv
module pp_refill_ctrl #(
    parameter int ADDR_W      = 15,
    parameter int MAX_INSTR   = 8192000,
    parameter int SYNC_STAGES = 2,
    localparam int CHUNK      = 1 << (ADDR_W - 1),
    localparam int SRC_W      = $clog2(MAX_INSTR + 1),
    localparam int LEN_W      = $clog2(CHUNK + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [SRC_W-1:0] total_instr,
    input  logic             seq_rd_msb,
    output logic             dma_req,
    input  logic             dma_ack,
    output logic [SRC_W-1:0] dma_src,
    output logic             dma_bank,
    output logic [LEN_W-1:0] dma_len,
    output logic             done
);

    logic             seq_bank_s;
    logic [SRC_W-1:0] calc_off;
    logic [SRC_W-1:0] calc_total;
    logic [LEN_W-1:0] calc_len;
    logic [SRC_W-1:0] calc_next;
    logic             calc_last;

    bank_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (seq_rd_msb),
        .sync_out (seq_bank_s)
    );

    chunk_calc #(
        .SRC_W (SRC_W),
        .LEN_W (LEN_W),
        .CHUNK (CHUNK)
    ) u_calc (
        .offset   (calc_off),
        .total    (calc_total),
        .len      (calc_len),
        .next_off (calc_next),
        .last     (calc_last)
    );

    refill_fsm #(
        .SRC_W (SRC_W),
        .LEN_W (LEN_W),
        .CHUNK (CHUNK)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .total_in   (total_instr),
        .seq_bank   (seq_bank_s),
        .dma_ack    (dma_ack),
        .calc_len   (calc_len),
        .calc_next  (calc_next),
        .calc_last  (calc_last),
        .calc_off   (calc_off),
        .calc_total (calc_total),
        .dma_req    (dma_req),
        .dma_src    (dma_src),
        .dma_bank   (dma_bank),
        .dma_len    (dma_len),
        .done       (done)
    );

endmodule

// File: tb/sim_pp_refill_ctrl.sv
module sim_pp_refill_ctrl;

    localparam int SRC_W = 23;
    localparam int LEN_W = 15;
    localparam int C     = 16384;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [SRC_W-1:0] total_instr = '0;
    logic             seq_rd_msb = 1'b0;
    logic             dma_ack = 1'b0;
    logic             dma_req;
    logic [SRC_W-1:0] dma_src;
    logic             dma_bank;
    logic [LEN_W-1:0] dma_len;
    logic             done;

    int vectors = 0;
    int miscompares = 0;

    always #2 clk = ~clk;

    pp_refill_ctrl u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .total_instr (total_instr),
        .seq_rd_msb  (seq_rd_msb),
        .dma_req     (dma_req),
        .dma_ack     (dma_ack),
        .dma_src     (dma_src),
        .dma_bank    (dma_bank),
        .dma_len     (dma_len),
        .done        (done)
    );

    function automatic longint exp_len(input longint total, input longint src);
        return (total - src >= C) ? C : total - src;
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic give_start(input longint total);
        start = 1'b1;
        total_instr = SRC_W'(total);
        step();
        start = 1'b0;
    endtask

    task automatic give_ack();
        dma_ack = 1'b1;
        step();
        dma_ack = 1'b0;
    endtask

    task automatic wait_req();
        for (int k = 0; k < 50 && !dma_req; k++) step();
    endtask

    task automatic chk_xfer(input string tag, input longint total, input int idx);
        chk({tag, " req"}, dma_req, 1);
        chk({tag, " src R7"}, dma_src, longint'(idx) * C);
        chk({tag, " bank R7"}, dma_bank, idx % 2);
        chk({tag, " len R8"}, dma_len, exp_len(total, longint'(idx) * C));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog (all) actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        void'($urandom(32'd7741));
        #1;
        step();
        // R1 reset state
        chk("R1 req in reset", dma_req, 0);
        chk("R1 done in reset", done, 0);
        rst_n = 1'b1;
        step();
        step();
        chk("R1 req idle", dma_req, 0);
        chk("R1 done idle", done, 0);

        // R11 zero total
        give_start(0);
        chk("R11 done", done, 1);
        chk("R11 req", dma_req, 0);

        // Directed run A: total 2C+100, pending change, short last chunk
        seq_rd_msb = 1'b0;
        step();
        step();
        give_start(2 * C + 100);
        chk_xfer("R2 R12 load", 2 * C + 100, 0);
        start = 1'b1;              // R10 start while loading
        total_instr = SRC_W'(5);
        step();
        start = 1'b0;
        step();
        chk_xfer("R3 R10 held", 2 * C + 100, 0);
        give_ack();
        chk("R3 drop after ack", dma_req, 0);
        step();
        chk_xfer("R4 first refill", 2 * C + 100, 1);
        seq_rd_msb = 1'b1;         // R6 change while busy
        for (int k = 0; k < 5; k++) step();
        chk_xfer("R6 busy held", 2 * C + 100, 1);
        give_ack();
        chk("R6 drop after ack", dma_req, 0);
        step();
        chk_xfer("R6 R8 pending", 2 * C + 100, 2);
        chk("R8 short len", dma_len, 100);
        give_ack();
        chk("R9 done", done, 1);
        chk("R9 no req", dma_req, 0);
        seq_rd_msb = 1'b0;
        for (int k = 0; k < 6; k++) step();
        chk("R9 quiet req", dma_req, 0);
        chk("R9 quiet done", done, 1);

        // Directed run B: exact latency of a bank change
        give_start(3 * C);
        chk_xfer("R12 restart", 3 * C, 0);
        give_ack();
        step();
        chk_xfer("R4 refill b1", 3 * C, 1);
        give_ack();
        for (int k = 0; k < 4; k++) begin
            step();
            chk("R5 no change no req", dma_req, 0);
        end
        seq_rd_msb = 1'b1;
        step();
        chk("R5 edge1", dma_req, 0);
        step();
        chk("R5 edge2", dma_req, 0);
        step();
        chk_xfer("R5 edge3", 3 * C, 2);
        give_ack();
        chk("R9 done B", done, 1);

        // Random runs
        for (int run = 0; run < 6; run++) begin
            longint total;
            int n;
            total = longint'($urandom_range(1, 5 * C));
            n = int'((total + C - 1) / C);
            seq_rd_msb = 1'b0;
            step();
            step();
            step();
            give_start(total);
            for (int i = 0; i < n; i++) begin
                if (i >= 2) seq_rd_msb = 1'((i - 1) % 2);
                wait_req();
                chk_xfer("R7 random", total, i);
                for (int d = int'($urandom_range(0, 3)); d > 0; d--) step();
                chk("R3 random hold", dma_req, 1);
                give_ack();
            end
            chk("R9 random done", done, 1);
            chk("R9 random no req", dma_req, 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule